// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block keeps a hidden descriptor (base, limit and a four-bit attribute field) for each of a set of segment registers, and turns a segment index plus a 32-bit offset into a 32-bit linear address. A request is checked against the selected segment's limit and, if the offset passes, the block returns base plus offset, with address bit 20 optionally cleared by an external A20 mask input. An offset beyond the limit produces a fault pulse and no address.

Segment loads come in two kinds. A real-mode load takes a 16-bit selector and sets the base to the selector times sixteen and the limit to 0xFFFF, leaving the attribute field alone. A protected-mode load writes base, limit and attributes directly from descriptor inputs. The block has no notion of a current mode: a descriptor stays exactly as the last load left it, so a protected-mode base (or the reset-time code base) stays in use under real-mode operation until that register is loaded again. At reset the code segment gets base 0xFFFF0000, so the first fetch at offset 0xFFF0 lands sixteen bytes below the top of the 4 GiB space.

Top module: `seg_linear_gen`

## Requirements
- R1: Synchronous active-low reset gives segment 1 (the code segment) base 0xFFFF0000 and every other segment base 0; all segments get limit 0xFFFF and attributes 0, and both result strobes are low. A code-segment request at offset 0xFFF0 after reset returns 0xFFFFFFF0.
- R2: A real-mode load (load_en high, load_prot low) sets the selected segment's base to load_sel shifted left by 4 and its limit to 0xFFFF.
- R3: Real-mode addresses are not cut to 20 bits: selector 0xFFFF with offset 0xFFFF yields 0x0010FFEF.
- R4: With a20_mask high in the request cycle, bit 20 of the returned address is zero and all other bits equal base plus offset.
- R5: A protected-mode load (load_en and load_prot high) writes load_base, load_limit and load_attr into the selected segment.
- R6: A descriptor changes only when a load targets its own index; a protected-mode descriptor stays in use after any number of loads to other segments.
- R7: A real-mode load to a segment that held a protected-mode descriptor restores the shifted-selector base and the 0xFFFF limit, while its attribute field is kept.
- R8: An offset greater than the limit gives out_fault high for one cycle with out_valid low; an offset equal to the limit is accepted.
- R9: The base-plus-offset sum wraps modulo 2^32.
- R10: Results appear exactly one cycle after the request; a load becomes visible to requests from the next cycle, so a request in the same cycle as a load to the same segment uses the previous descriptor.
- R11: out_attr carries the attribute field of the segment used, alongside out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Load a segment descriptor this cycle |
| load_prot | input | 1 | 1 = explicit descriptor load, 0 = selector load |
| load_seg | input | 3 | Index of the segment to load |
| load_sel | input | 16 | Selector for a real-mode load |
| load_base | input | 32 | Base for a protected-mode load |
| load_limit | input | 32 | Limit for a protected-mode load |
| load_attr | input | 4 | Attributes for a protected-mode load |
| req_valid | input | 1 | Address request strobe |
| req_seg | input | 3 | Segment index of the request |
| req_off | input | 32 | Offset of the request |
| a20_mask | input | 1 | Clear address bit 20 of this request |
| out_valid | output | 1 | Linear address valid |
| out_fault | output | 1 | Limit fault, one cycle |
| out_addr | output | 32 | Linear address |
| out_attr | output | 4 | Attributes of the segment used |

## Verification
Every request produces exactly one outcome, out_valid or out_fault, registered at the first rising edge after the request is sampled; a load likewise takes effect at its own edge and governs requests from the following cycle onward. The driver places each request on a falling edge and queues the expected outcome just after the next rising edge, and the monitor compares at the following falling edge, so each queued item meets the result of the single register stage. Cycles with an empty queue must show both strobes low, which catches results arriving late, early or twice. The same-cycle load-and-request case is driven in one falling edge to pin down which descriptor the request sees.

// File: rtl/seg_pkg.sv
// Shared constants and the descriptor type for the linear address generator.
// Assumes a 32-bit linear space and 16-bit selectors.
package seg_pkg;
    localparam int ADDR_W   = 32;
    localparam int SEL_W    = 16;
    localparam int ATTR_W   = 4;
    localparam int RM_SHIFT = 4;
    localparam int A20_BIT  = 20;
    localparam logic [ADDR_W-1:0] RM_LIMIT        = 32'h0000_FFFF;
    localparam logic [ADDR_W-1:0] CODE_RESET_BASE = 32'hFFFF_0000;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [ATTR_W-1:0] attr;
    } seg_desc_t;
endpackage

// File: rtl/seg_desc_cache.sv
// Hidden descriptor storage, one entry per segment register.
// Real-mode loads derive base from the selector; explicit loads copy the
// descriptor fields. No mode is stored: entries persist until reloaded.
// Assumes at most one load per cycle; the read port is combinational.
module seg_desc_cache
    import seg_pkg::*;
#(
    parameter int NUM_SEGS = 8,
    parameter int CODE_SEG = 1,
    localparam int SEG_W   = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_prot,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [SEG_W-1:0]  rd_idx,
    output seg_desc_t         rd_desc
);
    localparam int HI_ZERO = ADDR_W - SEL_W - RM_SHIFT;

    seg_desc_t desc_q [NUM_SEGS];
    logic [ADDR_W-1:0] rm_base;

    // Selector scaled by sixteen, zero-extended to the address width.
    always_comb rm_base = {{HI_ZERO{1'b0}}, wr_sel, {RM_SHIFT{1'b0}}};

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        localparam logic [ADDR_W-1:0] RST_BASE =
            (g == CODE_SEG) ? CODE_RESET_BASE : '0;

        // One descriptor entry: reset value, explicit load or selector load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_q[g].base  <= RST_BASE;
                desc_q[g].limit <= RM_LIMIT;
                desc_q[g].attr  <= '0;
            end else if (wr_en && wr_idx == SEG_W'(g)) begin
                if (wr_prot) begin
                    desc_q[g].base  <= wr_base;
                    desc_q[g].limit <= wr_limit;
                    desc_q[g].attr  <= wr_attr;
                end else begin
                    desc_q[g].base  <= rm_base;
                    desc_q[g].limit <= RM_LIMIT;
                end
            end
        end

        // R6
        keep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == SEG_W'(g)) |=> $stable(desc_q[g]));

        // R2
        rm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_prot && wr_idx == SEG_W'(g)) |=>
            (desc_q[g].base[RM_SHIFT-1:0] == '0 &&
             desc_q[g].base[ADDR_W-1:SEL_W+RM_SHIFT] == '0 &&
             desc_q[g].limit == RM_LIMIT));
    end

    // Combinational read of the addressed entry.
    always_comb rd_desc = desc_q[rd_idx];

    // R1
    code_reset_chk: assert property (@(posedge clk)
        !rst_n |=> desc_q[CODE_SEG].base == CODE_RESET_BASE);
endmodule

// File: rtl/seg_addr_unit.sv
// Limit check and linear address formation with one register stage.
// Assumes the descriptor presented is the one for the request's segment.
module seg_addr_unit
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_off,
    input  logic              a20_mask,
    input  seg_desc_t         desc,
    output logic              out_valid,
    output logic              out_fault,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ATTR_W-1:0] out_attr
);
    localparam logic [ADDR_W-1:0] A20_ONE = ADDR_W'(1) << A20_BIT;

    logic              over_lim;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] gated;

    // Offset beyond the byte limit faults; the sum wraps naturally.
    always_comb begin
        over_lim = req_off > desc.limit;
        sum      = desc.base + req_off;
        gated    = a20_mask ? (sum & ~A20_ONE) : sum;
    end

    // Result register: exactly one strobe per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_addr  <= '0;
            out_attr  <= '0;
        end else begin
            out_valid <= req_valid && !over_lim;
            out_fault <= req_valid && over_lim;
            if (req_valid && !over_lim) begin
                out_addr <= gated;
                out_attr <= desc.attr;
            end
        end
    end

    // R8
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault));

    // R8
    fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && over_lim) |=> out_fault);

    // R8
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fault && !req_valid) |=> !out_fault);

    // R4
    a20_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(a20_mask)) |-> !out_addr[A20_BIT]);

    // R10
    one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_fault) |-> $past(req_valid));
endmodule

// File: rtl/seg_linear_gen.sv
// Top level: descriptor cache feeding the address unit.
// Assumes load and request ports are driven synchronously to clk.
module seg_linear_gen
    import seg_pkg::*;
#(
    parameter int NUM_SEGS = 8,
    parameter int CODE_SEG = 1,
    localparam int SEG_W   = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_prot,
    input  logic [SEG_W-1:0]  load_seg,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [ADDR_W-1:0] load_limit,
    input  logic [ATTR_W-1:0] load_attr,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_off,
    input  logic              a20_mask,
    output logic              out_valid,
    output logic              out_fault,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ATTR_W-1:0] out_attr
);
    seg_desc_t cur_desc;

    seg_desc_cache #(.NUM_SEGS(NUM_SEGS), .CODE_SEG(CODE_SEG)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (load_en),
        .wr_prot  (load_prot),
        .wr_idx   (load_seg),
        .wr_sel   (load_sel),
        .wr_base  (load_base),
        .wr_limit (load_limit),
        .wr_attr  (load_attr),
        .rd_idx   (req_seg),
        .rd_desc  (cur_desc)
    );

    seg_addr_unit u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_off   (req_off),
        .a20_mask  (a20_mask),
        .desc      (cur_desc),
        .out_valid (out_valid),
        .out_fault (out_fault),
        .out_addr  (out_addr),
        .out_attr  (out_attr)
    );
endmodule

// File: tb/seg_linear_gen_bench.sv
module seg_linear_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0, load_prot = 1'b0;
    logic [2:0]  load_seg = '0;
    logic [15:0] load_sel = '0;
    logic [31:0] load_base = '0, load_limit = '0;
    logic [3:0]  load_attr = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [31:0] req_off = '0;
    logic        a20_mask = 1'b0;
    logic        out_valid, out_fault;
    logic [31:0] out_addr;
    logic [3:0]  out_attr;

    int applied = 0;
    int miscompares = 0;
    bit monitor_on = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        bit          v;
        bit          f;
        logic [31:0] a;
        logic [3:0]  at;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_linear_gen u_seg_linear_gen (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_prot(load_prot), .load_seg(load_seg),
        .load_sel(load_sel), .load_base(load_base), .load_limit(load_limit),
        .load_attr(load_attr),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .a20_mask(a20_mask),
        .out_valid(out_valid), .out_fault(out_fault),
        .out_addr(out_addr), .out_attr(out_attr)
    );

    task automatic push_exp(bit v, bit f, logic [31:0] a, logic [3:0] at, string tag);
        exp_t e;
        e.v = v; e.f = f; e.a = a; e.at = at; e.tag = tag;
        sb.push_back(e);
    endtask

    // Driver: request on a falling edge, expectation queued after the rising edge.
    task automatic issue(logic [2:0] seg, logic [31:0] off, bit a20,
                         bit f, logic [31:0] a, logic [3:0] at, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_off = off; a20_mask = a20;
        @(posedge clk);
        #1;
        push_exp(!f, f, a, at, tag);
        req_valid = 1'b0; a20_mask = 1'b0;
    endtask

    task automatic load_real(logic [2:0] seg, logic [15:0] sel);
        @(negedge clk);
        load_en = 1'b1; load_prot = 1'b0; load_seg = seg; load_sel = sel;
        @(posedge clk);
        #1 load_en = 1'b0;
    endtask

    task automatic load_desc(logic [2:0] seg, logic [31:0] base,
                             logic [31:0] lim, logic [3:0] at);
        @(negedge clk);
        load_en = 1'b1; load_prot = 1'b1; load_seg = seg;
        load_base = base; load_limit = lim; load_attr = at;
        @(posedge clk);
        #1 load_en = 1'b0;
    endtask

    // Monitor: compare the oldest expectation at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (monitor_on) begin
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    applied++;
                    if (out_valid !== e.v || out_fault !== e.f ||
                        (e.v && (out_addr !== e.a || out_attr !== e.at))) begin
                        miscompares++;
                        $display("FAIL %s: got v=%0b f=%0b addr=%08h attr=%h, expected v=%0b f=%0b addr=%08h attr=%h",
                                 e.tag, out_valid, out_fault, out_addr, out_attr,
                                 e.v, e.f, e.a, e.at);
                    end
                end else if (out_valid || out_fault) begin
                    applied++;
                    miscompares++;
                    $display("FAIL R10: got unrequested v=%0b f=%0b, expected v=0 f=0",
                             out_valid, out_fault);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        applied++;
        if (out_valid !== 1'b0 || out_fault !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: got v=%0b f=%0b in reset, expected 0 0", out_valid, out_fault);
        end
        rst_n = 1'b1;
        monitor_on = 1'b1;

        // R1: reset descriptors
        issue(3'd1, 32'h0000_FFF0, 0, 0, 32'hFFFF_FFF0, 4'h0, "R1 code fetch");
        issue(3'd3, 32'h0000_1234, 0, 0, 32'h0000_1234, 4'h0, "R1 data base 0");
        issue(3'd1, 32'h0001_0000, 0, 1, '0, 4'h0, "R1 reset limit R8");

        // R2: selector load
        load_real(3'd3, 16'h1234);
        issue(3'd3, 32'h0000_0005, 0, 0, 32'h0001_2345, 4'h0, "R2 shifted base");

        // R3: no 20-bit truncation
        load_real(3'd0, 16'hFFFF);
        issue(3'd0, 32'h0000_FFFF, 0, 0, 32'h0010_FFEF, 4'h0, "R3 top of HMA");
        issue(3'd0, 32'h0000_0000, 0, 0, 32'h000F_FFF0, 4'h0, "R3 base only");

        // R4: A20 mask
        issue(3'd0, 32'h0000_FFFF, 1, 0, 32'h0000_FFEF, 4'h0, "R4 masked wrap");
        issue(3'd3, 32'h0000_0005, 1, 0, 32'h0001_2345, 4'h0, "R4 bit already clear");

        // R8: limit boundary
        issue(3'd0, 32'h0001_0000, 0, 1, '0, 4'h0, "R8 one past limit");

        // R5 / R11: explicit descriptor
        load_desc(3'd2, 32'h00AB_C000, 32'h0000_FFFF, 4'h5);
        issue(3'd2, 32'h0000_0010, 0, 0, 32'h00AB_C010, 4'h5, "R5 R11 explicit base");

        // R6: other loads leave it alone
        load_real(3'd4, 16'h0100);
        load_real(3'd5, 16'h0200);
        issue(3'd2, 32'h0000_0020, 0, 0, 32'h00AB_C020, 4'h5, "R6 retained");
        issue(3'd4, 32'h0000_0001, 0, 0, 32'h0000_1001, 4'h0, "R2 other seg");

        // R7: selector load restores a normal base, keeps attributes
        load_real(3'd2, 16'h0200);
        issue(3'd2, 32'h0000_0030, 0, 0, 32'h0000_2030, 4'h5, "R7 restored base R11");
        issue(3'd2, 32'h0001_0000, 0, 1, '0, 4'h0, "R7 limit back to 0xFFFF");

        // R9: wrap
        load_desc(3'd5, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 4'hA);
        issue(3'd5, 32'h0000_0020, 0, 0, 32'h0000_0010, 4'hA, "R9 wrap");

        // R8 / R4 with a large limit
        load_desc(3'd6, 32'h0010_0000, 32'h000F_FFFF, 4'h3);
        issue(3'd6, 32'h000F_FFFF, 0, 0, 32'h001F_FFFF, 4'h3, "R8 equal to limit");
        issue(3'd6, 32'h0010_0000, 0, 1, '0, 4'h0, "R8 above limit");
        issue(3'd6, 32'h0000_0000, 1, 0, 32'h0000_0000, 4'h3, "R4 masked base");

        // R10: load and request in the same cycle
        @(negedge clk);
        load_en = 1'b1; load_prot = 1'b0; load_seg = 3'd3; load_sel = 16'h0050;
        req_valid = 1'b1; req_seg = 3'd3; req_off = 32'h1;
        @(posedge clk);
        #1;
        push_exp(1, 0, 32'h0001_2341, 4'h0, "R10 old descriptor");
        load_en = 1'b0; req_valid = 1'b0;
        issue(3'd3, 32'h0000_0001, 0, 0, 32'h0000_0501, 4'h0, "R10 new descriptor");

        // R1: code segment still untouched
        issue(3'd1, 32'h0000_FFFF, 0, 0, 32'hFFFF_FFFF, 4'h0, "R1 code top byte");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            miscompares++;
            $display("FAIL R10: got %0d results missing, expected 0", sb.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule